// File: doc/BRIEF.md
# Three-Mode Interrupt Response Sequencer

This block is the interrupt-acceptance part of a small 8-bit processor core. It holds a maskable-interrupt enable flag, a two-bit response-mode register and an 8-bit vector-page register, all set by simple commands from the core's decoder. The core signals each instruction boundary. When an enabled request is seen at a boundary, or at any time while the core is halted, the sequencer takes over the memory port and performs one of three responses.

In **fixed-restart mode** (mode 1), the program counter is pushed and execution continues at a fixed restart address. In **device-opcode mode** (mode 0), the device supplies one byte during an acknowledge cycle. A restart opcode of the form `11ttt111` is pushed and jumped to `ttt*8`. Any other byte is passed to the core for execution. In **table mode** (mode 2, and also mode 3), a pointer is formed from the page register (upper byte) and the device byte (lower byte). The program counter is pushed, a little-endian 16-bit handler address is read from the pointer, and the core jumps to it.

The sequencer states are: IDLE, HALTED, ACK (acknowledge strobe, device byte captured), OPOUT (opcode handed to the core), PUSH_HI, PUSH_LO, VEC_LO, VEC_HI and JUMP. The transitions are as follows:
- IDLE→HALTED on a halt command.
- IDLE or HALTED→PUSH_HI on acceptance in mode 1.
- IDLE or HALTED→ACK on acceptance in the other modes.
- ACK→PUSH_HI for table mode or for a restart opcode, and ACK→OPOUT otherwise.
- OPOUT→IDLE.
- PUSH_HI→PUSH_LO.
- PUSH_LO→VEC_LO in table mode, and PUSH_LO→JUMP otherwise.
- VEC_LO→VEC_HI→JUMP.
- JUMP→IDLE.

Top module: `irq_resp_seq`

## Requirements
- R1: After reset the enable flag is 0, the mode is 0, the page is 0, `halted` is 0, and `inta`, `mem_req`, `op_valid` and `jump_valid` are all 0.
- R2: Command codes are 0 = disable, 1 = enable, 2 = set mode (`cmd_arg[1:0]`), 3 = set page (`cmd_arg`) and 4 = halt. Commands are applied only in IDLE. Enable makes `int_en` 1 and disable makes it 0. While `int_en` is 0, a request produces no `inta`, no `mem_req` and no `jump_valid`.
- R3: In IDLE, a request is sampled only in a cycle with `insn_done` high. A request held while `insn_done` is low is not taken.
- R4: Accepting an interrupt clears `int_en`, so the request stays masked after the response. A command presented in the accepting cycle is discarded.
- R5: Every push writes the PC high byte at SP-1 and then the PC low byte at SP-2, on consecutive cycles. `sp_out` equals SP-2 when `jump_valid` is high.
- R6: In mode 1 there is no `inta` cycle. The push starts the cycle after acceptance, and `jump_valid` with `jump_pc` = 0x0038 arrives 3 cycles after the accepting edge.
- R7: In modes 2 and 3, one `inta` cycle captures `dev_data` and the pointer {page, dev_data} is formed. After the push, the low handler byte is read at the pointer and the high byte at pointer+1. `jump_valid` then arrives 6 cycles after acceptance.
- R8: In mode 0, a device byte matching `11ttt111` leads to a push and then a jump to `ttt*8`, 4 cycles after acceptance.
- R9: In mode 0, any other device byte pulses `op_valid` for one cycle with `op_byte` equal to that byte, 2 cycles after acceptance. No memory access and no `jump_valid` occur.
- R10: A halt command raises `halted`. The block stays halted while no enabled request is present. An enabled request leaves the halt state without `insn_done`, and the response then runs with the same timing as from IDLE.
- R11: Only one of `inta`, `mem_req`, `op_valid` and `jump_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Control command strobe |
| cmd_code | input | 3 | Command code (see R2) |
| cmd_arg | input | 8 | Command argument (mode or page) |
| insn_done | input | 1 | Core is at an instruction boundary |
| int_req | input | 1 | Maskable interrupt request (level) |
| cur_pc | input | 16 | Program counter to save |
| cur_sp | input | 16 | Stack pointer before the push |
| dev_data | input | 8 | Byte supplied by the device during `inta` |
| inta | output | 1 | Acknowledge strobe, one cycle per device byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as a read request |
| op_valid | output | 1 | Device opcode handed to the core |
| op_byte | output | 8 | The handed-over opcode |
| jump_valid | output | 1 | Response complete, load PC and SP |
| jump_pc | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| int_en | output | 1 | Maskable interrupt enable flag |
| halted | output | 1 | Core is in the halt state |

## Verification
Each result has a fixed cycle offset from the accepting edge. Counting from that edge:
- The acknowledge strobe, when present, is in cycle 1.
- Memory accesses fall in cycles 1–2 for mode 1 and in cycles 2–3 (plus table reads in cycles 4–5) for the other modes.
- The jump or opcode hand-off lands in cycle 3, 4 or 6 for a jump, or in cycle 2 for the hand-off.

The bench drives the request half a cycle before the accepting edge. It then samples once per cycle at the falling edge, numbering the samples from that edge, and records every strobe and memory access with its cycle number. Each is compared with the cycle expected for the mode and device byte. Tests that check that nothing happens hold the stimulus for several cycles and watch the ports throughout.

// File: rtl/irs_pkg.sv
package irs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALTED,
        ST_ACK,
        ST_OPOUT,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_JUMP
    } irs_state_t;

    localparam logic [2:0] CMD_DI   = 3'd0;
    localparam logic [2:0] CMD_EI   = 3'd1;
    localparam logic [2:0] CMD_MODE = 3'd2;
    localparam logic [2:0] CMD_PAGE = 3'd3;
    localparam logic [2:0] CMD_HALT = 3'd4;

endpackage

// File: rtl/irs_cfg_regs.sv
module irs_cfg_regs
    import irs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [DATA_W-1:0] cmd_arg,
    input  logic              idle,
    input  logic              take,
    output logic              ie,
    output logic [1:0]        mode,
    output logic [DATA_W-1:0] page,
    output logic              halt_go
);

    logic apply;
    assign apply   = cmd_valid && idle && !take;
    assign halt_go = apply && (cmd_code == CMD_HALT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            mode <= 2'd0;
            page <= '0;
        end else if (take) begin
            ie <= 1'b0;
        end else if (apply) begin
            case (cmd_code)
                CMD_DI:   ie   <= 1'b0;
                CMD_EI:   ie   <= 1'b1;
                CMD_MODE: mode <= cmd_arg[1:0];
                CMD_PAGE: page <= cmd_arg;
                default:  ;
            endcase
        end
    end

    // R4
    take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ie);

    // R2
    ei_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && cmd_code == CMD_EI) |=> ie);

endmodule

// File: rtl/irs_fsm.sv
module irs_fsm
    import irs_pkg::*;
#(
    parameter int              DATA_W      = 8,
    parameter int              ADDR_W      = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] RESTART_VEC = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              int_req,
    input  logic              ie_i,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] page,
    input  logic              halt_go,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] cur_sp,
    input  logic [DATA_W-1:0] dev_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output irs_state_t        st,
    output logic              take,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              inta,
    output logic              op_valid,
    output logic [DATA_W-1:0] op_byte,
    output logic              jump_valid,
    output logic [ADDR_W-1:0] jump_pc,
    output logic [ADDR_W-1:0] sp_out
);

    irs_state_t        nxt;
    logic [ADDR_W-1:0] tgt_q;
    logic [DATA_W-1:0] byte_q;
    logic              is_rst;
    logic              table_mode;

    assign table_mode = mode[1];
    assign is_rst     = (dev_data[7:6] == 2'b11) && (dev_data[2:0] == 3'b111);
    assign take       = ie_i && int_req &&
                        (((st == ST_IDLE) && insn_done) || (st == ST_HALTED));

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (take)         nxt = (mode == 2'd1) ? ST_PUSH_HI : ST_ACK;
                else if (halt_go) nxt = ST_HALTED;
            end
            ST_HALTED:  if (take) nxt = (mode == 2'd1) ? ST_PUSH_HI : ST_ACK;
            ST_ACK:     nxt = (table_mode || is_rst) ? ST_PUSH_HI : ST_OPOUT;
            ST_OPOUT:   nxt = ST_IDLE;
            ST_PUSH_HI: nxt = ST_PUSH_LO;
            ST_PUSH_LO: nxt = table_mode ? ST_VEC_LO : ST_JUMP;
            ST_VEC_LO:  nxt = ST_VEC_HI;
            ST_VEC_HI:  nxt = ST_JUMP;
            ST_JUMP:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            sp_q   <= '0;
            ptr_q  <= '0;
            tgt_q  <= '0;
            byte_q <= '0;
        end else begin
            if (take) begin
                pc_q  <= cur_pc;
                sp_q  <= cur_sp;
                tgt_q <= RESTART_VEC;
            end
            if (st == ST_ACK) begin
                byte_q <= dev_data;
                ptr_q  <= {page, dev_data};
                if (!table_mode)
                    tgt_q <= {{(ADDR_W-6){1'b0}}, dev_data[5:3], 3'b000};
            end
            if (st == ST_VEC_LO) tgt_q[DATA_W-1:0]      <= mem_rdata;
            if (st == ST_VEC_HI) tgt_q[ADDR_W-1:DATA_W] <= mem_rdata;
        end
    end

    always_comb begin
        inta       = (st == ST_ACK);
        op_valid   = (st == ST_OPOUT);
        op_byte    = byte_q;
        jump_valid = (st == ST_JUMP);
        jump_pc    = tgt_q;
        sp_out     = sp_q - ADDR_W'(2);
    end

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALTED && !(ie_i && int_req)) |=> st == ST_HALTED);

    // R2
    masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ie_i) |=> (st == ST_IDLE || st == ST_HALTED));

    // R3
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !insn_done) |=> (st == ST_IDLE || st == ST_HALTED));

endmodule

// File: rtl/irs_mem_port.sv
module irs_mem_port
    import irs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irs_state_t        st,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [ADDR_W-1:0] ptr_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            ST_PUSH_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - ADDR_W'(1);
                mem_wdata = pc_q[ADDR_W-1:DATA_W];
            end
            ST_PUSH_LO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - ADDR_W'(2);
                mem_wdata = pc_q[DATA_W-1:0];
            end
            ST_VEC_LO: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q;
            end
            ST_VEC_HI: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + ADDR_W'(1);
            end
            default: ;
        endcase
    end

    // R5
    push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && st == ST_PUSH_HI) |=>
            (mem_req && mem_we && mem_addr == $past(mem_addr) - ADDR_W'(1)));

    // R7
    table_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && st == ST_VEC_LO) |=>
            (mem_req && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));

endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
    import irs_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [2*DATA_W-1:0] RESTART_VEC = 16'h0038
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_code,
    input  logic [DATA_W-1:0]     cmd_arg,
    input  logic                  insn_done,
    input  logic                  int_req,
    input  logic [2*DATA_W-1:0]   cur_pc,
    input  logic [2*DATA_W-1:0]   cur_sp,
    input  logic [DATA_W-1:0]     dev_data,
    output logic                  inta,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  op_valid,
    output logic [DATA_W-1:0]     op_byte,
    output logic                  jump_valid,
    output logic [2*DATA_W-1:0]   jump_pc,
    output logic [2*DATA_W-1:0]   sp_out,
    output logic                  int_en,
    output logic                  halted
);

    localparam int ADDR_W = 2 * DATA_W;

    irs_state_t        st;
    logic              take, halt_go;
    logic [1:0]        mode;
    logic [DATA_W-1:0] page;
    logic [ADDR_W-1:0] pc_q, sp_q, ptr_q;

    assign halted = (st == ST_HALTED);

    irs_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .idle(st == ST_IDLE), .take(take), .ie(int_en),
        .mode(mode), .page(page), .halt_go(halt_go)
    );

    irs_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESTART_VEC(RESTART_VEC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .int_req(int_req),
        .ie_i(int_en), .mode(mode), .page(page), .halt_go(halt_go),
        .cur_pc(cur_pc), .cur_sp(cur_sp), .dev_data(dev_data),
        .mem_rdata(mem_rdata), .st(st), .take(take), .pc_q(pc_q), .sp_q(sp_q),
        .ptr_q(ptr_q), .inta(inta), .op_valid(op_valid), .op_byte(op_byte),
        .jump_valid(jump_valid), .jump_pc(jump_pc), .sp_out(sp_out)
    );

    irs_mem_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .st(st), .pc_q(pc_q), .sp_q(sp_q),
        .ptr_q(ptr_q), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inta, mem_req, op_valid, jump_valid}));

    // R9
    op_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !mem_req && !jump_valid);

endmodule

// File: tb/irq_resp_seq_tb.sv
`timescale 1ns/1ps
module irq_resp_seq_tb;
    import irs_pkg::*;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = '0;
    logic [7:0]  cmd_arg = '0;
    logic        insn_done = 1'b0;
    logic        int_req = 1'b0;
    logic [15:0] cur_pc = '0;
    logic [15:0] cur_sp = '0;
    logic [7:0]  dev_data = '0;
    logic        inta, mem_req, mem_we, op_valid, jump_valid, int_en, halted;
    logic [15:0] mem_addr, jump_pc, sp_out;
    logic [7:0]  mem_wdata, mem_rdata, op_byte;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = memf(mem_addr);

    irq_resp_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .insn_done(insn_done), .int_req(int_req),
        .cur_pc(cur_pc), .cur_sp(cur_sp), .dev_data(dev_data), .inta(inta),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .op_valid(op_valid),
        .op_byte(op_byte), .jump_valid(jump_valid), .jump_pc(jump_pc),
        .sp_out(sp_out), .int_en(int_en), .halted(halted)
    );

    // fields: mode[49:48] page[47:40] dev[39:32] pc[31:16] sp[15:0]
    localparam int NV = 10;
    localparam logic [49:0] VECS [NV] = '{
        {2'd1, 8'h00, 8'h00, 16'h1234, 16'hFFF0},
        {2'd2, 8'h80, 8'h10, 16'h2345, 16'h8000},
        {2'd2, 8'h3C, 8'hFE, 16'h0100, 16'h0002},
        {2'd0, 8'h00, 8'hFF, 16'hABCD, 16'hC000},
        {2'd0, 8'h00, 8'hC7, 16'h5566, 16'h4000},
        {2'd0, 8'h00, 8'hEF, 16'h0F0F, 16'h2222},
        {2'd0, 8'h00, 8'h3E, 16'h7777, 16'h3000},
        {2'd3, 8'h11, 8'h22, 16'h9ABC, 16'hE000},
        {2'd0, 8'h00, 8'hCF, 16'h0042, 16'h1000},
        {2'd0, 8'h00, 8'hC6, 16'h4321, 16'h1800}
    };

    logic        ev_we [8];
    logic [15:0] ev_a  [8];
    logic [7:0]  ev_d  [8];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] code, input logic [7:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_quiet(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(req, {inta, mem_req, op_valid, jump_valid}, 4'b0);
        end
    endtask

    task automatic run_int(input logic [1:0] m, input logic [7:0] pg,
                           input logic [7:0] dv, input logic [15:0] pc,
                           input logic [15:0] sp, input bit from_halt);
        logic [15:0] tgt, ptr;
        int lat, nack, nev, n_ack, got_j, got_op, n_push;
        logic [15:0] jpc, spo;
        logic [7:0]  opb;
        bit rst_op;
        rst_op = (dv[7:6] == 2'b11) && (dv[2:0] == 3'b111);
        ptr = {pg, dv};
        if (m == 2'd1) begin
            tgt = 16'h0038; lat = 3; nack = 0;
        end else if (m[1]) begin
            tgt = {memf(ptr + 16'd1), memf(ptr)}; lat = 6; nack = 1;
        end else if (rst_op) begin
            tgt = {10'd0, dv[5:3], 3'b000}; lat = 4; nack = 1;
        end else begin
            tgt = 16'h0; lat = 2; nack = 1;
        end
        n_push = (lat == 2) ? 0 : 2;
        send(CMD_MODE, {6'd0, m});
        send(CMD_PAGE, pg);
        send(CMD_EI, 8'h00);
        if (from_halt) begin
            send(CMD_HALT, 8'h00);
            chk("R10 halted after halt command", halted, 1);
            check_quiet("R10 halt holds without request", 3);
            chk("R10 still halted", halted, 1);
        end
        cur_pc = pc; cur_sp = sp; dev_data = dv;
        int_req = 1'b1; insn_done = !from_halt;
        nev = 0; n_ack = 0; got_j = 0; got_op = 0;
        jpc = '0; spo = '0; opb = '0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            insn_done = 1'b0;
            if (n == 1) begin
                chk("R4 enable cleared on accept", int_en, 0);
                if (from_halt) chk("R10 left halt", halted, 0);
            end
            if (inta) begin
                n_ack++;
                chk("R7/R8/R9 inta cycle", n, 1);
            end
            if (mem_req && nev < 8) begin
                ev_we[nev] = mem_we; ev_a[nev] = mem_addr; ev_d[nev] = mem_wdata;
                chk("R5/R6/R7 access cycle", n, (m == 2'd1) ? nev + 1 : nev + 2);
                nev++;
            end
            if (jump_valid) begin
                got_j++;
                jpc = jump_pc; spo = sp_out;
                chk("R6/R7/R8 jump latency", n, lat);
            end
            if (op_valid) begin
                got_op++;
                opb = op_byte;
                chk("R9 opcode latency", n, lat);
            end
        end
        int_req = 1'b0;
        chk("R6/R7/R8/R9 inta count", n_ack, nack);
        chk("R4 enable stays cleared", int_en, 0);
        chk("R5/R7 access count", nev, n_push + (m[1] ? 2 : 0));
        if (n_push == 2) begin
            chk("R5 high byte push", {ev_we[0], ev_a[0], ev_d[0]},
                {1'b1, sp - 16'd1, pc[15:8]});
            chk("R5 low byte push", {ev_we[1], ev_a[1], ev_d[1]},
                {1'b1, sp - 16'd2, pc[7:0]});
            chk("R6/R7/R8 jump seen once", got_j, 1);
            chk("R6/R7/R8 jump target", jpc, tgt);
            chk("R5 new SP", spo, sp - 16'd2);
            chk("R9 no opcode hand-off", got_op, 0);
        end else begin
            chk("R9 opcode seen once", got_op, 1);
            chk("R9 opcode byte", opb, dv);
            chk("R9 no jump", got_j, 0);
        end
        if (m[1]) begin
            chk("R7 table low read", {ev_we[2], ev_a[2]}, {1'b0, ptr});
            chk("R7 table high read", {ev_we[3], ev_a[3]}, {1'b0, ptr + 16'd1});
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 int_en after reset", int_en, 0);
        chk("R1 halted after reset", halted, 0);
        chk("R1 strobes after reset", {inta, mem_req, op_valid, jump_valid}, 4'b0);
        rst_n = 1'b1;

        // R2 masked request ignored
        int_req = 1'b1; insn_done = 1'b1;
        check_quiet("R2 masked request ignored", 4);
        chk("R2 flag stays low", int_en, 0);
        int_req = 1'b0; insn_done = 1'b0;

        // R2 enable and disable
        send(CMD_EI, 8'h00);
        chk("R2 enable sets flag", int_en, 1);
        send(CMD_DI, 8'h00);
        chk("R2 disable clears flag", int_en, 0);

        // R3 no boundary, no acceptance
        send(CMD_MODE, 8'h01);
        send(CMD_EI, 8'h00);
        int_req = 1'b1; insn_done = 1'b0;
        check_quiet("R3 no boundary", 5);
        chk("R3 flag untouched", int_en, 1);
        int_req = 1'b0;
        send(CMD_DI, 8'h00);

        // table of responses from IDLE
        for (int v = 0; v < NV; v++) begin
            run_int(VECS[v][49:48], VECS[v][47:40], VECS[v][39:32],
                    VECS[v][31:16], VECS[v][15:0], 1'b0);
            check_quiet("R4 request masked after response", 2);
        end

        // R10 exit from halt, mode 1 and mode 2
        run_int(2'd1, 8'h00, 8'h00, 16'hBEEF, 16'h7000, 1'b1);
        run_int(2'd2, 8'h44, 8'h9A, 16'hC0DE, 16'h6000, 1'b1);

        // R10 halt with interrupts disabled stays halted
        send(CMD_DI, 8'h00);
        send(CMD_HALT, 8'h00);
        int_req = 1'b1;
        check_quiet("R10 masked halt holds", 4);
        chk("R10 masked halt still halted", halted, 1);
        int_req = 1'b0;

        // R1 reset leaves halt
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 halted cleared by reset", halted, 0);
        chk("R1 int_en cleared by reset", int_en, 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule